// File: doc/BRIEF.md
# Two-Stage Operand Routing Crossbar

This block moves results from the output latches of their producers to the operand inputs of their consumers. Each producer owns a latch that keeps its result until the next result is written into it. The crossbar reads straight from those latches, so it needs no central register file. Sources come in two classes. Fast sources are single-result producers with a one-cycle latency. Slow sources are producers that deliver more than one result, or that take two or more cycles.

Each consumer port has its own final multiplexer. That multiplexer sees only the fast latches plus one extra input. The extra input is a slow value that a registered pre-selection stage picked one cycle earlier. Keeping the slow sources out of the final stage holds its fan-in small.

The rename logic computes every select code in advance. The slow pre-select code for a port arrives one cycle before the final code that consumes the pre-selected value. A final code of all ones leaves the operand undriven.

Top module: `operand_router`

## Requirements
- R1: After reset every operand output is zero with its valid flag low, and every fast and slow latch holds zero.
- R2: A latch whose write enable is high at a clock edge takes the write data at that edge. A latch whose enable is low keeps its value.
- R3: A final code k below N_FAST (codes 0 to 3 with the defaults) makes the port output the contents of fast latch k after the next edge, with valid high.
- R4: A pre-select code s at edge k captures slow latch s into the port's pre-selection register. A final code equal to N_FAST (4 with the defaults) at edge k+1 drives that captured value onto the port after edge k+1, with valid high.
- R5: A final code above N_FAST, including the all-ones code (7 with the defaults), gives a zero operand with valid low after the next edge.
- R6: A pre-select code at or above N_SLOW (6 or 7 with the defaults) loads zero into the pre-selection register.
- R7: Each port routes by its own codes. Several ports may read the same source in the same cycle, and each port gets that source.
- R8: A selection made in the same cycle as a write to the selected latch returns the latch's previous value. The new value can be selected from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_wen | input | N_FAST | Write enable per fast result latch |
| fast_wdata | input | N_FAST*DATA_W | Write data per fast latch, latch i in bits [i*DATA_W +: DATA_W] |
| slow_wen | input | N_SLOW | Write enable per slow result latch |
| slow_wdata | input | N_SLOW*DATA_W | Write data per slow latch, same packing |
| pre_code | input | N_PORTS*SSEL_W | Per-port slow pre-select code, issued one cycle ahead |
| final_code | input | N_PORTS*FSEL_W | Per-port final select code: fast index, N_FAST for slow, above N_FAST undriven |
| opnd_data | output | N_PORTS*DATA_W | Routed operand per consumer port |
| opnd_vld | output | N_PORTS | Operand driven flag per port |

## Verification
Some rules hold on every cycle, and the assertions check these. They are latch capture and hold, the one-cycle routing of fast sources, the handoff from the pre-selection register to the final stage, and the zero output for undriven or out-of-range codes. Other behaviour needs a timed chain of stimulus that only the bench's scenarios can show. The first is the full two-edge path of a slow result from its latch write to its consumer. The second is a read of a latch in the same cycle it is written. The third is the contents of the latches right after reset. The last is independent selection when several ports request sources at once.

// File: rtl/router_pkg.sv
package router_pkg;

    // Final code: fast indices, one slow slot, and room for an all-ones "undriven" value.
    function automatic int final_code_width(int n_fast);
        return $clog2(n_fast + 2);
    endfunction

    function automatic int pre_code_width(int n_slow);
        return (n_slow < 2) ? 1 : $clog2(n_slow);
    endfunction

endpackage

// File: rtl/result_latch_bank.sv
module result_latch_bank #(
    parameter int DATA_W = 32,
    parameter int COUNT  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [COUNT-1:0]        wen,
    input  logic [COUNT*DATA_W-1:0] wdata,
    output logic [COUNT*DATA_W-1:0] q
);

    typedef struct packed {
        logic [COUNT*DATA_W-1:0] val;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < COUNT; i++) begin
            if (wen[i]) begin
                s_d.val[i*DATA_W +: DATA_W] = wdata[i*DATA_W +: DATA_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign q = s_q.val;

    for (genvar i = 0; i < COUNT; i++) begin : g_chk
        assert_latch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !wen[i] |=> $stable(q[i*DATA_W +: DATA_W]))
            else $error("latch %0d changed without write", i);
        assert_latch_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
            wen[i] |=> q[i*DATA_W +: DATA_W] == $past(wdata[i*DATA_W +: DATA_W]))
            else $error("latch %0d missed its write", i);
    end

endmodule

// File: rtl/slow_preselect.sv
module slow_preselect #(
    parameter int DATA_W  = 32,
    parameter int N_SLOW  = 6,
    parameter int N_PORTS = 3,
    parameter int SSEL_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_SLOW*DATA_W-1:0]  src,
    input  logic [N_PORTS*SSEL_W-1:0] code,
    output logic [N_PORTS*DATA_W-1:0] pre
);

    typedef struct packed {
        logic [N_PORTS*DATA_W-1:0] val;
    } pre_t;

    pre_t s_d, s_q;

    always_comb begin
        s_d = '0;
        for (int p = 0; p < N_PORTS; p++) begin
            for (int s = 0; s < N_SLOW; s++) begin
                if (code[p*SSEL_W +: SSEL_W] == SSEL_W'(s)) begin
                    s_d.val[p*DATA_W +: DATA_W] = src[s*DATA_W +: DATA_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pre = s_q.val;

    localparam logic [SSEL_W:0] SLOW_LIM = (SSEL_W + 1)'(N_SLOW);

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        assert_pre_oob_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ({1'b0, code[p*SSEL_W +: SSEL_W]} >= SLOW_LIM) |=> pre[p*DATA_W +: DATA_W] == '0)
            else $error("port %0d out-of-range preselect not zero", p);
        for (genvar s = 0; s < N_SLOW; s++) begin : g_src
            assert_pre_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (code[p*SSEL_W +: SSEL_W] == SSEL_W'(s))
                |=> pre[p*DATA_W +: DATA_W] == $past(src[s*DATA_W +: DATA_W]))
                else $error("port %0d preselect of slow %0d wrong", p, s);
        end
    end

endmodule

// File: rtl/fast_final_mux.sv
module fast_final_mux #(
    parameter int DATA_W  = 32,
    parameter int N_FAST  = 4,
    parameter int N_PORTS = 3,
    parameter int FSEL_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_FAST*DATA_W-1:0]  fast_src,
    input  logic [N_PORTS*DATA_W-1:0] pre,
    input  logic [N_PORTS*FSEL_W-1:0] code,
    output logic [N_PORTS*DATA_W-1:0] data,
    output logic [N_PORTS-1:0]        vld
);

    localparam logic [FSEL_W-1:0] SLOW_CODE = FSEL_W'(N_FAST);

    typedef struct packed {
        logic [N_PORTS*DATA_W-1:0] data;
        logic [N_PORTS-1:0]        vld;
    } out_t;

    out_t s_d, s_q;

    always_comb begin
        s_d = '0;
        for (int p = 0; p < N_PORTS; p++) begin
            for (int f = 0; f < N_FAST; f++) begin
                if (code[p*FSEL_W +: FSEL_W] == FSEL_W'(f)) begin
                    s_d.data[p*DATA_W +: DATA_W] = fast_src[f*DATA_W +: DATA_W];
                    s_d.vld[p]                   = 1'b1;
                end
            end
            if (code[p*FSEL_W +: FSEL_W] == SLOW_CODE) begin
                s_d.data[p*DATA_W +: DATA_W] = pre[p*DATA_W +: DATA_W];
                s_d.vld[p]                   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign data = s_q.data;
    assign vld  = s_q.vld;

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        assert_undriven_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (code[p*FSEL_W +: FSEL_W] > SLOW_CODE)
            |=> (!vld[p] && data[p*DATA_W +: DATA_W] == '0))
            else $error("port %0d driven on undriven code", p);
        assert_slow_handoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (code[p*FSEL_W +: FSEL_W] == SLOW_CODE)
            |=> (vld[p] && data[p*DATA_W +: DATA_W] == $past(pre[p*DATA_W +: DATA_W])))
            else $error("port %0d slow handoff wrong", p);
        for (genvar f = 0; f < N_FAST; f++) begin : g_src
            assert_fast_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (code[p*FSEL_W +: FSEL_W] == FSEL_W'(f))
                |=> (vld[p] && data[p*DATA_W +: DATA_W] == $past(fast_src[f*DATA_W +: DATA_W])))
                else $error("port %0d fast route of %0d wrong", p, f);
        end
    end

endmodule

// File: rtl/operand_router.sv
module operand_router
    import router_pkg::*;
#(
    parameter int  DATA_W  = 32,
    parameter int  N_FAST  = 4,
    parameter int  N_SLOW  = 6,
    parameter int  N_PORTS = 3,
    localparam int FSEL_W  = final_code_width(N_FAST),
    localparam int SSEL_W  = pre_code_width(N_SLOW)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_FAST-1:0]         fast_wen,
    input  logic [N_FAST*DATA_W-1:0]  fast_wdata,
    input  logic [N_SLOW-1:0]         slow_wen,
    input  logic [N_SLOW*DATA_W-1:0]  slow_wdata,
    input  logic [N_PORTS*SSEL_W-1:0] pre_code,
    input  logic [N_PORTS*FSEL_W-1:0] final_code,
    output logic [N_PORTS*DATA_W-1:0] opnd_data,
    output logic [N_PORTS-1:0]        opnd_vld
);

    logic [N_FAST*DATA_W-1:0]  fast_q;
    logic [N_SLOW*DATA_W-1:0]  slow_q;
    logic [N_PORTS*DATA_W-1:0] pre_q;

    result_latch_bank #(.DATA_W(DATA_W), .COUNT(N_FAST)) i_fast_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wen   (fast_wen),
        .wdata (fast_wdata),
        .q     (fast_q)
    );

    result_latch_bank #(.DATA_W(DATA_W), .COUNT(N_SLOW)) i_slow_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wen   (slow_wen),
        .wdata (slow_wdata),
        .q     (slow_q)
    );

    slow_preselect #(
        .DATA_W (DATA_W),
        .N_SLOW (N_SLOW),
        .N_PORTS(N_PORTS),
        .SSEL_W (SSEL_W)
    ) i_preselect (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (slow_q),
        .code  (pre_code),
        .pre   (pre_q)
    );

    fast_final_mux #(
        .DATA_W (DATA_W),
        .N_FAST (N_FAST),
        .N_PORTS(N_PORTS),
        .FSEL_W (FSEL_W)
    ) i_final (
        .clk      (clk),
        .rst_n    (rst_n),
        .fast_src (fast_q),
        .pre      (pre_q),
        .code     (final_code),
        .data     (opnd_data),
        .vld      (opnd_vld)
    );

endmodule

// File: tb/test_operand_router.sv
`timescale 1ns/1ps
module test_operand_router;

    localparam int DATA_W  = 32;
    localparam int N_FAST  = 4;
    localparam int N_SLOW  = 6;
    localparam int N_PORTS = 3;
    localparam int FSEL_W  = 3;
    localparam int SSEL_W  = 3;
    localparam logic [2:0] UNDRIVEN = 3'd7;
    localparam logic [2:0] SLOWSLOT = 3'd4;

    // Each entry: {pre2, pre1, pre0, fin2, fin1, fin0}, 3 bits each.
    localparam int NVEC = 8;
    localparam logic [17:0] VEC [NVEC] = '{
        18'o210210, 18'o534444, 18'o760473, 18'o111444,
        18'o222564, 18'o543333, 18'o000404, 18'o123444
    };

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [N_FAST-1:0]         fast_wen = '0;
    logic [N_FAST*DATA_W-1:0]  fast_wdata = '0;
    logic [N_SLOW-1:0]         slow_wen = '0;
    logic [N_SLOW*DATA_W-1:0]  slow_wdata = '0;
    logic [N_PORTS*SSEL_W-1:0] pre_code = '0;
    logic [N_PORTS*FSEL_W-1:0] final_code = {N_PORTS{UNDRIVEN}};
    logic [N_PORTS*DATA_W-1:0] opnd_data;
    logic [N_PORTS-1:0]        opnd_vld;

    int checks = 0;
    int errors = 0;

    logic [DATA_W-1:0] fast_m [N_FAST];
    logic [DATA_W-1:0] slow_m [N_SLOW];
    logic [DATA_W-1:0] pre_m  [N_PORTS];

    always #2.5 clk = ~clk;

    operand_router #(
        .DATA_W(DATA_W), .N_FAST(N_FAST), .N_SLOW(N_SLOW), .N_PORTS(N_PORTS)
    ) i_operand_router (
        .clk(clk), .rst_n(rst_n),
        .fast_wen(fast_wen), .fast_wdata(fast_wdata),
        .slow_wen(slow_wen), .slow_wdata(slow_wdata),
        .pre_code(pre_code), .final_code(final_code),
        .opnd_data(opnd_data), .opnd_vld(opnd_vld)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        summary();
        $finish;
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_port(int p, logic [DATA_W-1:0] ed, logic ev, string req);
        logic [DATA_W-1:0] ad;
        ad = opnd_data[p*DATA_W +: DATA_W];
        checks++;
        if (ad !== ed || opnd_vld[p] !== ev) begin
            errors++;
            $display("FAIL %s port %0d: actual %h/%b expected %h/%b", req, p, ad, opnd_vld[p], ed, ev);
        end
    endtask

    task automatic idle();
        fast_wen   = '0;
        slow_wen   = '0;
        pre_code   = '0;
        final_code = {N_PORTS{UNDRIVEN}};
    endtask

    initial begin
        logic [2:0] fc, pc;
        for (int i = 0; i < N_FAST; i++) fast_m[i] = '0;
        for (int i = 0; i < N_SLOW; i++) slow_m[i] = '0;
        for (int i = 0; i < N_PORTS; i++) pre_m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: outputs after reset
        for (int p = 0; p < N_PORTS; p++) check_port(p, '0, 1'b0, "R1 reset output");

        // R1: latches cleared by reset (fast 0..2 read zero, driven)
        final_code = {3'd2, 3'd1, 3'd0};
        tick();
        for (int p = 0; p < N_PORTS; p++) check_port(p, '0, 1'b1, "R1 fast latch reset");
        final_code = {N_PORTS{SLOWSLOT}};
        pre_code   = {3'd5, 3'd3, 3'd0};
        tick();
        tick();
        for (int p = 0; p < N_PORTS; p++) check_port(p, '0, 1'b1, "R1 slow latch reset");
        idle();

        // Load every latch (R2 capture)
        for (int i = 0; i < N_FAST; i++) begin
            fast_m[i] = 32'hA0A0_0000 + 32'(i * 17);
            fast_wdata[i*DATA_W +: DATA_W] = fast_m[i];
        end
        for (int i = 0; i < N_SLOW; i++) begin
            slow_m[i] = 32'h5A00_0100 + 32'(i * 3);
            slow_wdata[i*DATA_W +: DATA_W] = slow_m[i];
        end
        fast_wen = '1;
        slow_wen = '1;
        tick();
        fast_wen = '0;
        slow_wen = '0;
        // R2 hold: new write data with enable low must not land
        fast_wdata = '1;
        slow_wdata = '1;
        tick();

        // Vector walk: R3 fast, R4 slow, R5 undriven, R6 out-of-range, R7 independence
        for (int v = 0; v < NVEC; v++) begin
            logic [DATA_W-1:0] ed [N_PORTS];
            logic              ev [N_PORTS];
            for (int p = 0; p < N_PORTS; p++) begin
                fc = VEC[v][p*3 +: 3];
                pc = VEC[v][9 + p*3 +: 3];
                final_code[p*FSEL_W +: FSEL_W] = fc;
                pre_code[p*SSEL_W +: SSEL_W]   = pc;
                if (fc < SLOWSLOT) begin
                    ed[p] = fast_m[fc]; ev[p] = 1'b1;
                end else if (fc == SLOWSLOT) begin
                    ed[p] = pre_m[p]; ev[p] = 1'b1;
                end else begin
                    ed[p] = '0; ev[p] = 1'b0;
                end
                pre_m[p] = (pc < 3'(N_SLOW)) ? slow_m[pc] : '0;
            end
            tick();
            for (int p = 0; p < N_PORTS; p++)
                check_port(p, ed[p], ev[p], "R2/R3/R4/R5/R6/R7 vector");
        end
        idle();

        // R8: select fast 2 while it is being written -> old value, then new
        fast_wen[2] = 1'b1;
        fast_wdata[2*DATA_W +: DATA_W] = 32'hC0DE_0002;
        final_code[0 +: FSEL_W] = 3'd2;
        tick();
        check_port(0, fast_m[2], 1'b1, "R8 fast same-cycle write");
        fast_m[2] = 32'hC0DE_0002;
        fast_wen = '0;
        tick();
        check_port(0, fast_m[2], 1'b1, "R8 fast new value");

        // R4/R8: slow latch write, then preselect, then final select
        slow_wen[5] = 1'b1;
        slow_wdata[5*DATA_W +: DATA_W] = 32'hBEEF_0005;
        pre_code[0 +: SSEL_W] = 3'd5;
        final_code[0 +: FSEL_W] = UNDRIVEN;
        tick();
        check_port(0, '0, 1'b0, "R5 undriven code");
        slow_wen = '0;
        final_code[0 +: FSEL_W] = SLOWSLOT;
        tick();
        check_port(0, slow_m[5], 1'b1, "R8 slow same-cycle write");
        slow_m[5] = 32'hBEEF_0005;
        pre_code[0 +: SSEL_W] = 3'd6;
        tick();
        check_port(0, slow_m[5], 1'b1, "R4 slow path two edges");
        tick();
        check_port(0, '0, 1'b1, "R6 out-of-range preselect");

        // R7: all ports read the same fast source
        final_code = {3'd3, 3'd3, 3'd3};
        tick();
        for (int p = 0; p < N_PORTS; p++) check_port(p, fast_m[3], 1'b1, "R7 shared source");

        summary();
        $finish;
    end

endmodule